// File: doc/BRIEF.md
# Sampling Converter Serial Readout Port

This block is the device-side digital logic of a single-channel 14-bit sampling converter with a three-wire serial interface. A host lowers the active-low select line, toggles the serial clock 16 times and reads back one 16-bit frame. The frame holds two zero bits and then the 14-bit conversion result, most significant bit first. The result comes from a behavioural model of the analog core and is presented on a parallel input.

The block runs on a fast internal clock and oversamples the select and serial-clock pins through synchronizer chains. A falling select edge captures the result and puts the track/hold into hold. It also enables the data-line driver with the first zero already on the line. Each later bit is launched by a serial-clock falling edge. The track/hold goes back to track on the rising edge after the 15th falling edge. The driver turns off on the 16th falling edge, or at once if select rises early.

The data line is modelled as a value plus a driver enable. The pad ring builds the actual high-impedance buffer from these two signals.

Top module: `sar_serial_port`

## Requirements
- R1: After reset, `sdata_oe`, `hold` and `sdata` are all 0.
- R2: Within SYNC_STAGES+2 clock cycles of a falling edge on `cs_n`, `hold` is 1, `sdata_oe` is 1 and `sdata` shows 0 (the first leading zero), before any serial-clock edge.
- R3: A frame carries two 0 bits and then `result[13]` down to `result[0]`. After the k-th `sclk` falling edge (k = 1..15), `sdata` shows frame bit k, where frame bit 0 is the first zero, bit 1 the second zero, and bit k for k >= 2 is `result[15-k]`.
- R4: Rising `sclk` edges do not change `sdata`. After the 15th falling edge, `sdata` holds `result[0]` until the 16th falling edge.
- R5: `hold` stays 1 until the first `sclk` rising edge after the 15th falling edge, and goes to 0 on that edge.
- R6: On the 16th `sclk` falling edge, `sdata_oe` goes to 0 and `sdata` to 0.
- R7: If `cs_n` rises before 16 falling edges, `sdata_oe` and `hold` both go to 0 at once and the frame is abandoned.
- R8: `sclk` edges while `cs_n` is high leave all outputs unchanged. The next frame still starts from the first leading zero.
- R9: `result` is captured only on the falling edge of `cs_n`. Changes to `result` during the shift do not alter the frame.
- R10: Every `cs_n` falling edge restarts the bit count, including the one that follows an abandoned frame.
- R11: `sclk` edges after the 16th falling edge, while `cs_n` is still low, leave `sdata_oe`, `hold` and `sdata` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select pin (asynchronous) |
| sclk | input | 1 | Serial clock pin (asynchronous) |
| result | input | DATA_W | Conversion result from the analog model |
| sdata | output | 1 | Serial data value (0 when not driven) |
| sdata_oe | output | 1 | Data-line driver enable |
| hold | output | 1 | Track/hold control, 1 = hold |

## Verification
The assertions assume that `cs_n` and `sclk` change slowly compared with `clk`. Each pin level must last longer than the synchronizer chain, so that no edge is lost and no falling and rising edge of the same pin land in one sample. The bench holds every pin level for eight clock cycles, which is twice the worst-case path through synchronizer, edge register and output register. It also never moves `cs_n` and `sclk` in the same cycle. With this spacing, the counter-based properties about when `hold` falls and when the driver is enabled reflect real pin ordering.

// File: rtl/sar_serial_port.sv
module sar_serial_port #(
  parameter int DATA_W      = 14,
  parameter int LEAD_ZEROS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] result,
  output logic              sdata,
  output logic              sdata_oe,
  output logic              hold
);

  localparam int FRAME_W = DATA_W + LEAD_ZEROS;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(FRAME_W);

  logic [SYNC_STAGES-1:0] cs_sync, sck_sync;
  logic                   cs_d, sck_d;
  logic                   cs_s, sck_s;
  logic                   cs_fall, cs_rise, sck_fall, sck_rise;

  logic                   active;
  logic [CNT_W-1:0]       fall_cnt;
  logic [FRAME_W-1:0]     shreg;
  logic                   oe_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync  <= '1;
      sck_sync <= '1;
      cs_d     <= 1'b1;
      sck_d    <= 1'b1;
    end else begin
      cs_sync  <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      sck_sync <= {sck_sync[SYNC_STAGES-2:0], sclk};
      cs_d     <= cs_s;
      sck_d    <= sck_s;
    end
  end

  assign cs_s     = cs_sync[SYNC_STAGES-1];
  assign sck_s    = sck_sync[SYNC_STAGES-1];
  assign cs_fall  = cs_d & ~cs_s;
  assign cs_rise  = ~cs_d & cs_s;
  assign sck_fall = sck_d & ~sck_s;
  assign sck_rise = ~sck_d & sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      fall_cnt <= '0;
      shreg    <= '0;
      oe_q     <= 1'b0;
      hold_q   <= 1'b0;
    end else if (cs_fall) begin
      shreg    <= {{LEAD_ZEROS{1'b0}}, result};
      fall_cnt <= '0;
      active   <= 1'b1;
      oe_q     <= 1'b1;
      hold_q   <= 1'b1;
    end else if (cs_rise) begin
      active   <= 1'b0;
      oe_q     <= 1'b0;
      hold_q   <= 1'b0;
    end else if (active) begin
      if (sck_fall) begin
        if (fall_cnt == LAST) begin
          fall_cnt <= DONE;
          active   <= 1'b0;
          oe_q     <= 1'b0;
        end else begin
          fall_cnt <= fall_cnt + 1'b1;
          shreg    <= {shreg[FRAME_W-2:0], 1'b0};
        end
      end
      if (sck_rise && fall_cnt == LAST) hold_q <= 1'b0;
    end
  end

  assign sdata    = oe_q & shreg[FRAME_W-1];
  assign sdata_oe = oe_q;
  assign hold     = hold_q;

endmodule

module sar_serial_port_chk #(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sdata,
  input logic             sdata_oe,
  input logic             hold,
  input logic             active,
  input logic [CNT_W-1:0] fall_cnt
);

  // R5
  hold_needs_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> sdata_oe);

  // R6
  quiet_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata);

  // R2
  first_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> !sdata && hold);

  // R5
  track_on_last_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold) && active) |-> fall_cnt == CNT_W'(FRAME_W - 1));

  // R11
  count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_cnt <= CNT_W'(FRAME_W));

  // R3
  lead_zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && fall_cnt < 2) |-> !sdata);

endmodule

bind sar_serial_port sar_serial_port_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdata(sdata), .sdata_oe(sdata_oe), .hold(hold),
  .active(active), .fall_cnt(fall_cnt)
);

// File: tb/test_sar_serial_port.sv
module test_sar_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [13:0] result = '0;
  logic        sdata, sdata_oe, hold;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  sar_serial_port i_sar_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .result(result),
    .sdata(sdata), .sdata_oe(sdata_oe), .hold(hold)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (HALF) @(negedge clk);
  endtask

  function automatic logic frame_bit(input logic [13:0] v, input int k);
    logic [15:0] f = {2'b00, v};
    return f[15-k];
  endfunction

  task automatic t_reset();
    chk("R1 oe", sdata_oe, 1'b0);
    chk("R1 hold", hold, 1'b0);
    chk("R1 sdata", sdata, 1'b0);
  endtask

  task automatic t_full_frame(input logic [13:0] v, input bit scramble);
    result = v;
    cs_n = 1'b0; settle();
    chk("R2 oe", sdata_oe, 1'b1);
    chk("R2 hold", hold, 1'b1);
    chk("R2 first zero", sdata, 1'b0);
    if (scramble) result = ~v;
    for (int k = 1; k <= 16; k++) begin
      sclk = 1'b0; settle();
      if (k <= 15) begin
        chk(scramble ? "R9 bit" : "R3 bit", sdata, frame_bit(v, k));
        chk("R3 oe", sdata_oe, 1'b1);
      end else begin
        chk("R6 oe off", sdata_oe, 1'b0);
        chk("R6 sdata", sdata, 1'b0);
      end
      sclk = 1'b1; settle();
      if (k <= 15) chk("R4 stable on rise", sdata, frame_bit(v, k));
      if (k < 15) chk("R5 still hold", hold, 1'b1);
      else chk("R5 track", hold, 1'b0);
    end
    cs_n = 1'b1; settle();
  endtask

  task automatic t_abort(input logic [13:0] v, input int nfall);
    result = v;
    cs_n = 1'b0; settle();
    for (int k = 1; k <= nfall; k++) begin
      sclk = 1'b0; settle();
      sclk = 1'b1; settle();
    end
    cs_n = 1'b1; settle();
    chk("R7 oe off", sdata_oe, 1'b0);
    chk("R7 hold off", hold, 1'b0);
    chk("R7 sdata", sdata, 1'b0);
  endtask

  task automatic t_idle_clocks();
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b0; settle();
      chk("R8 oe idle", sdata_oe, 1'b0);
      chk("R8 hold idle", hold, 1'b0);
      sclk = 1'b1; settle();
    end
  endtask

  task automatic t_extra_clocks(input logic [13:0] v);
    result = v;
    cs_n = 1'b0; settle();
    for (int k = 1; k <= 16; k++) begin
      sclk = 1'b0; settle();
      sclk = 1'b1; settle();
    end
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b0; settle();
      chk("R11 oe", sdata_oe, 1'b0);
      chk("R11 hold", hold, 1'b0);
      chk("R11 sdata", sdata, 1'b0);
      sclk = 1'b1; settle();
    end
    cs_n = 1'b1; settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1; settle();
    t_reset();
    t_full_frame(14'h3FFF, 0);
    t_full_frame(14'h2A55, 0);
    t_full_frame(14'h0001, 0);
    t_full_frame(14'h1C3A, 1);
    t_abort(14'h3FFF, 0);
    t_abort(14'h3FFF, 5);
    t_abort(14'h3FFF, 15);
    t_full_frame(14'h2001, 0); // R10 restart after abort
    t_idle_clocks();
    t_full_frame(14'h3FFF, 0); // R8 next frame starts at first zero
    t_extra_clocks(14'h3FFF);
    t_full_frame(14'h0F0F, 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule